// File: doc/BRIEF.md
# Keyed Watchdog Timer with Write-Once Mode Lock

This block is a watchdog counter behind a small byte-wide register port with two locations. Software restarts it by writing one fixed key byte to a restart location. A mode location sets the counting clock and the overflow period. The mode can be accepted only once after reset. The block raises a one-clock reset request in two cases: the counter reaches its terminal count, or software touches either location in a way that is not allowed. A surrounding reset controller is expected to act on that pulse.

The write strobe carries a flag that marks single-bit read-modify-write accesses. Such accesses are treated apart from full byte writes. The counter either advances on every system clock or on a low-speed tick pulse supplied from outside. Setting the stop bit in the single accepted mode write freezes the counter. It also turns every access that would otherwise be illegal into a harmless one.

Top module: `keyed_watchdog`

## Requirements
- R1: A full-byte write of ACh to the restart location (sel = 1) clears the counter. The next reset request follows exactly 2^(BASE_EXP+N) counting ticks after that write edge.
- R2: Reading the restart location always returns 9Ah, both after reset and after any write to it.
- R3: A full-byte write of any value other than ACh to the restart location makes rst_req high for one clock, in the cycle after the write edge.
- R4: A write with wr_bit = 1 to the restart location raises the reset request, whatever its data, even when the data is ACh.
- R5: The mode location (sel = 0) reads 67h after reset. The first full-byte write whose bits 7..5 equal 011 is stored, locks the location and clears the counter. The location then reads back the stored value.
- R6: Once the mode location is locked, another full-byte write to it raises the reset request.
- R7: A write with wr_bit = 1 to the mode location is ignored: the value is not changed, the location is not locked, and no reset request is raised.
- R8: A first mode write whose bits 7..5 differ from 011 raises the reset request and is neither stored nor locked.
- R9: When the accepted mode has bit 4 = 1, the counter stops and never overflows. A wrong key, a bit-level restart access and a second mode write then raise no request.
- R10: Mode bit 3 selects the counting tick: 1 counts on every clock, 0 counts only on clocks with slow_tick high.
- R11: Mode bits 2..0 give N, and the period is 2^(BASE_EXP+N) ticks. Before any mode write the block uses N = 7 on the slow tick.
- R12: A valid key write in the same cycle as the terminal tick wins: the counter clears and no request is raised. An illegal access in the same cycle as an overflow gives one single-clock pulse.
- R13: rst_n low at a clock edge restores the mode value 67h, clears the lock, the counter and rst_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-clock pulse from the low-speed clock domain |
| wr_en | input | 1 | Write strobe |
| wr_bit | input | 1 | Marks the write as a single-bit manipulation |
| sel | input | 1 | Location select: 0 mode, 1 restart |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected location |
| rst_req | output | 1 | One-clock internal reset request |

## Verification
A restart key and the terminal tick can land on the same clock edge. So can an illegal access and an overflow. The bench uses the fast system-clock tick with the shortest period. It counts idle cycles from the accepted mode write so that its next write hits the exact edge where the counter holds its last value. For the key case, it expects rst_req to stay low and a full fresh period to follow. For the wrong-key case, it expects exactly one high cycle, then low, then a fresh period.

// File: rtl/kwdt_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a one-bit location select and an eight-bit data path.
package kwdt_pkg;

    localparam logic [7:0] KEY_BYTE   = 8'hAC;   // restart key
    localparam logic [7:0] KEY_READ   = 8'h9A;   // fixed read value of restart location
    localparam logic [7:0] MODE_RESET = 8'h67;   // mode value out of reset
    localparam logic [2:0] MODE_TOP   = 3'b011;  // required pattern on mode bits 7..5

    typedef enum logic {
        LOC_MODE    = 1'b0,
        LOC_RESTART = 1'b1
    } kwdt_loc_e;

    // Decoded mode fields used by the counter
    typedef struct packed {
        logic       halt;     // stop counting
        logic       fast;     // 1: count every clock, 0: count on slow tick
        logic [2:0] span;     // period exponent offset
    } kwdt_cfg_t;

endpackage

// File: rtl/kwdt_regs.sv
// Register front end: holds the write-once mode byte and decodes every access.
// It reports a restart, a mode load or an illegal access as single-cycle flags.
// Assumes at most one write per clock and a synchronous active-low reset.
module kwdt_regs
    import kwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_bit,
    input  logic       sel,
    input  logic [7:0] wdata,
    output logic [7:0] mode_byte,
    output kwdt_cfg_t  cfg,
    output logic       restart,
    output logic       mode_load,
    output logic       illegal
);

    logic [7:0] mode_q;
    logic       locked_q;
    logic       halted;
    logic       wr_mode;
    logic       wr_key;

    assign halted  = locked_q & mode_q[4];
    assign wr_mode = wr_en & (sel == LOC_MODE);
    assign wr_key  = wr_en & (sel == LOC_RESTART);

    // Classify the current write as restart, mode load or violation
    always_comb begin
        restart   = 1'b0;
        mode_load = 1'b0;
        illegal   = 1'b0;
        if (wr_key) begin
            if (!wr_bit && wdata == KEY_BYTE) begin
                restart = 1'b1;
            end else begin
                illegal = ~halted;
            end
        end else if (wr_mode && !wr_bit) begin
            if (locked_q) begin
                illegal = ~halted;
            end else if (wdata[7:5] == MODE_TOP) begin
                mode_load = 1'b1;
            end else begin
                illegal = 1'b1;
            end
        end
    end

    // Store the mode byte and set the lock on the accepted first write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_RESET;
            locked_q <= 1'b0;
        end else if (mode_load) begin
            mode_q   <= wdata;
            locked_q <= 1'b1;
        end
    end

    assign mode_byte = mode_q;
    assign cfg.halt  = halted;
    assign cfg.fast  = mode_q[3];
    assign cfg.span  = mode_q[2:0];

    // R5/R6: a locked mode byte never changes until reset
    a_r6_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(mode_q));

    // R7: bit-level mode writes leave the stored byte alone
    a_r7_bit_mode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit && sel == LOC_MODE) |=> $stable(mode_q) && $stable(locked_q));

endmodule

// File: rtl/kwdt_counter.sv
// Watchdog counter: advances on the selected tick and flags overflow at the period end.
// A clear request always beats the terminal tick in the same cycle.
// Assumes slow_tick is already a one-clock pulse in the clk domain.
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int BASE_EXP = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      slow_tick,
    input  kwdt_cfg_t cfg,
    input  logic      clear,
    output logic      overflow
);

    localparam int SPAN_MAX = 7;
    localparam int CNT_W    = BASE_EXP + SPAN_MAX;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span_pow;
    logic [CNT_W-1:0] term_m1;
    logic             tick;

    // Pick the counting tick from the mode fields
    always_comb begin
        if (cfg.halt) begin
            tick = 1'b0;
        end else if (cfg.fast) begin
            tick = 1'b1;
        end else begin
            tick = slow_tick;
        end
    end

    // Terminal value is one below 2^(BASE_EXP+span)
    always_comb begin
        span_pow = (CNT_W+1)'(1) << (BASE_EXP + int'(cfg.span));
        term_m1  = CNT_W'(span_pow - (CNT_W+1)'(1));
    end

    assign overflow = tick & ~clear & (cnt_q == term_m1);

    // Advance, wrap at the terminal value, or clear on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || overflow) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R11: the count never passes the selected terminal value
    a_r11_within_period: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= term_m1);

    // R9: a halted counter stays at its value
    a_r9_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.halt && !clear) |=> $stable(cnt_q));

    // R1: a clear leaves the count at zero
    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/keyed_watchdog.sv
// Top of the keyed watchdog: register front end, counter and reset-request flop.
// rst_req is registered, so it rises in the cycle after the causing edge.
// Assumes a synchronous active-low reset and a one-clock slow_tick pulse.
module keyed_watchdog
    import kwdt_pkg::*;
#(
    parameter int BASE_EXP = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic       wr_en,
    input  logic       wr_bit,
    input  logic       sel,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rst_req
);

    kwdt_cfg_t  cfg;
    logic [7:0] mode_byte;
    logic       restart;
    logic       mode_load;
    logic       illegal;
    logic       overflow;
    logic       rst_req_q;

    kwdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bit    (wr_bit),
        .sel       (sel),
        .wdata     (wdata),
        .mode_byte (mode_byte),
        .cfg       (cfg),
        .restart   (restart),
        .mode_load (mode_load),
        .illegal   (illegal)
    );

    kwdt_counter #(
        .BASE_EXP (BASE_EXP)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .cfg       (cfg),
        .clear     (restart | mode_load),
        .overflow  (overflow)
    );

    // Merge both request sources into one registered pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= overflow | illegal;
        end
    end

    // Return the fixed value or the mode byte
    always_comb begin
        rdata = (sel == LOC_RESTART) ? KEY_READ : mode_byte;
    end

    assign rst_req = rst_req_q;

    // R3/R4: a bad restart access while running always leads to a request
    a_r3_bad_key_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == LOC_RESTART && !cfg.halt && (wr_bit || wdata != KEY_BYTE))
        |=> rst_req);

    // R12: a good key write is never followed by a request
    a_r12_key_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == LOC_RESTART && !wr_bit && wdata == KEY_BYTE) |=> !rst_req);

    // R9: no request can come out of a halted watchdog
    a_r9_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.halt && $past(cfg.halt)) |-> !rst_req);

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

    localparam int BEXP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_bit = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rst_req;

    int vectors = 0;
    int misses  = 0;

    keyed_watchdog #(.BASE_EXP(BEXP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .wr_en     (wr_en),
        .wr_bit    (wr_bit),
        .sel       (sel),
        .wdata     (wdata),
        .rdata     (rdata),
        .rst_req   (rst_req)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int expv);
        vectors++;
        if (act != expv) begin
            misses++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_bit = 1'b0; sel = 1'b0; wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called at a negedge; the write lands on the next posedge, returns at the negedge after it
    task automatic wr(input logic s, input logic [7:0] d, input logic bitop);
        wr_en = 1'b1; sel = s; wdata = d; wr_bit = bitop;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_bit = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [7:0] v);
        sel = s; #1; v = rdata;
    endtask

    // Clock edges after the last write until rst_req is seen high
    task automatic measure(input int limit, output int got);
        got = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (rst_req) begin
                got = i;
                return;
            end
        end
    endtask

    task automatic quiet(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset();
        check("R13 rst_req after reset", int'(rst_req), 0);
        rd(1'b1, v); check("R2 restart read after reset", v, 8'h9A);
        rd(1'b0, v); check("R5 mode read after reset", v, 8'h67);
    endtask

    task automatic t_key_default_period();
        logic [7:0] v; int got;
        do_reset(); slow_tick = 1'b1;
        wr(1'b1, 8'hAC, 1'b0);
        check("R1 no request after key", int'(rst_req), 0);
        rd(1'b1, v); check("R2 restart read after key write", v, 8'h9A);
        measure(3000, got);
        check("R11 default period 2^(B+7)", got, 1 << (BEXP + 7));
    endtask

    task automatic t_wrong_key();
        logic [7:0] v; int seen;
        do_reset(); slow_tick = 1'b1;
        wr(1'b1, 8'h55, 1'b0);
        check("R3 request after wrong key", int'(rst_req), 1);
        @(negedge clk);
        check("R3 request is one clock", int'(rst_req), 0);
        rd(1'b1, v); check("R2 restart read after wrong key", v, 8'h9A);
        wr(1'b1, 8'hAC, 1'b1);
        check("R4 bit access with key data", int'(rst_req), 1);
        wr(1'b1, 8'h00, 1'b1);
        check("R4 bit access with other data", int'(rst_req), 1);
        quiet(1, seen);
        check("R4 pulse ends", seen, 0);
    endtask

    task automatic t_mode_fast();
        logic [7:0] v; int got;
        do_reset(); slow_tick = 1'b0;
        wr(1'b0, 8'h68, 1'b0);
        check("R5 no request on valid mode write", int'(rst_req), 0);
        rd(1'b0, v); check("R5 mode read back", v, 8'h68);
        measure(200, got);
        check("R10 fast tick period N=0", got, 1 << BEXP);
        wr(1'b1, 8'hAC, 1'b0);
        wr(1'b0, 8'h69, 1'b0);
        check("R6 second mode write requests", int'(rst_req), 1);
        rd(1'b0, v); check("R6 mode unchanged by second write", v, 8'h68);
    endtask

    task automatic t_mode_bit_and_bad();
        logic [7:0] v; int got;
        do_reset(); slow_tick = 1'b1;
        wr(1'b0, 8'h6A, 1'b1);
        check("R7 no request on bit mode write", int'(rst_req), 0);
        rd(1'b0, v); check("R7 mode unchanged by bit write", v, 8'h67);
        wr(1'b0, 8'h11, 1'b0);
        check("R8 bad top bits request", int'(rst_req), 1);
        rd(1'b0, v); check("R8 mode not stored", v, 8'h67);
        wr(1'b0, 8'h69, 1'b0);
        check("R7 still unlocked, byte write accepted", int'(rst_req), 0);
        rd(1'b0, v); check("R7 later byte write stored", v, 8'h69);
        measure(200, got);
        check("R11 period N=1 fast", got, 1 << (BEXP + 1));
    endtask

    task automatic t_stopped();
        logic [7:0] v; int seen;
        do_reset(); slow_tick = 1'b1;
        wr(1'b0, 8'h70, 1'b0);
        quiet(3000, seen);
        check("R9 halted never overflows", seen, 0);
        wr(1'b1, 8'h12, 1'b0);
        wr(1'b1, 8'hAC, 1'b1);
        wr(1'b0, 8'h68, 1'b0);
        quiet(2, seen);
        check("R9 illegal accesses silent when halted", seen, 0);
        rd(1'b0, v); check("R9 mode stays halted", v, 8'h70);
    endtask

    task automatic t_slow_select();
        int seen; int got;
        do_reset(); slow_tick = 1'b0;
        wr(1'b0, 8'h60, 1'b0);
        quiet(100, seen);
        check("R10 slow select without ticks", seen, 0);
        slow_tick = 1'b1;
        measure(200, got);
        check("R10 slow select period N=0", got, 1 << BEXP);
        slow_tick = 1'b0;
    endtask

    task automatic t_coincide();
        int seen; int got;
        do_reset(); slow_tick = 1'b0;
        wr(1'b0, 8'h68, 1'b0);
        quiet((1 << BEXP) - 1, seen);
        check("R12 quiet before terminal edge", seen, 0);
        wr(1'b1, 8'hAC, 1'b0);
        check("R12 key beats terminal tick", int'(rst_req), 0);
        measure(200, got);
        check("R12 fresh period after key", got, 1 << BEXP);
        quiet((1 << BEXP) - 1, seen);
        check("R12 quiet before second terminal edge", seen, 0);
        wr(1'b1, 8'h33, 1'b0);
        check("R12 merged request high", int'(rst_req), 1);
        @(negedge clk);
        check("R12 merged request one clock", int'(rst_req), 0);
        measure(200, got);
        check("R12 fresh period after merged overflow", got, (1 << BEXP) - 1);
    endtask

    initial begin
        #(20ns * 150000);
        misses++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        t_reset_state();
        t_key_default_period();
        t_wrong_key();
        t_mode_fast();
        t_mode_bit_and_bad();
        t_stopped();
        t_slow_select();
        t_coincide();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule